// File: doc/BRIEF.md
# Command-List I2C Master Sequencer

This block is the sequencing half of a byte-level I2C master. Software loads a short list of command words into a small register-mapped command store. It then writes a launch bit, and the sequencer walks the list from entry 0. Each command can ask for a START condition, one byte transmitted or received, the acknowledge policy after a received byte, and a STOP condition. The sequencer turns these into single-operation requests to an external bit timing engine. That engine is outside this block and drives SCL and SDA.

A transmit command takes the entry that follows it as its data byte, so an address phase or a data byte uses two entries. Received bytes are packed little-endian into a small data store that reads back as 32-bit words. The list ends at the highest entry written since the previous launch. A status word reports progress, the current entry and sticky flags, and some of those flags are cleared by writing 1. A missing acknowledge stops the run at the failing entry. A timed soft reset returns the sequencer to a clean state, so that later transfers to responsive targets succeed. The interrupt output combines the done and error flags with their enable bits.

Register word addresses: 0 control, 1 status, 2 launch, 16..31 command entries (low 8 bits used), 32..35 data words. Engine operation codes on `eng_op`: 0 START, 1 STOP, 2 transmit byte, 3 receive byte.

Top module: `i2c_cmdseq`

## Requirements
- R1: After reset, the status and control words read 0, `irq` is low, `eng_go` is low and `eng_rst` is low.
- R2: Writing 1 to launch bit 0 starts a run at entry 0 only if control bit 1 (core enable) and bit 2 (master mode) are both set. Otherwise the write is ignored: busy stays 0 and no engine request is made.
- R3: A command word uses bit 7 START, bit 6 STOP, bit 5 receive, bit 4 transmit, bit 3 NACK-after-receive and bits 2:0 repeat. The engine requests come in the order START, data operation(s), STOP. Each request is a one-cycle `eng_go` pulse. When both bit 5 and bit 4 are set, the transmit wins.
- R4: A transmit command sends the byte held in the next entry, and execution continues two entries later. Any other command advances by one entry.
- R5: The nth byte received in a run (counted from 0) is stored in data word n/4, bits 8·(n mod 4)+7 down to 8·(n mod 4). The count restarts at each launch and wraps at 16 bytes.
- R6: The data operation of a command is issued repeat+1 times. For a receive with bit 3 set, `eng_nack` is high only on the final repetition.
- R7: Status bits: 0 busy, 1 engine operation outstanding, 2 NACK received, 4 byte transferred, 6 STOP issued this run, 8 list done, 9 error, and 20:16 the current entry index. Done is set when the index reaches the loaded length, which is one more than the highest entry written since the previous launch.
- R8: A transmit that the target does not acknowledge sets status bits 9 and 2, ends the run without setting done, keeps the failing entry in bits 20:16, and issues no further engine request.
- R9: Writing 1 to status bit 2, 4, 8 or 9 clears that flag. If the sequencer sets a flag in the same cycle, the set wins.
- R10: Writing 1 to control bit 0 starts a soft reset that lasts RST_CYCLES cycles. During it, control bit 0 reads 1, `eng_rst` is high, the run is dropped, the status flags, index, loaded length and data store are cleared, and register writes are ignored. The enable bits keep the value of the write that started the reset. A later run then completes normally.
- R11: `irq` is high exactly when (done and control bit 11) or (error and control bit 12).
- R12: Writing 0 to launch bit 0 during a run stops it at once: busy drops, done is not set, and a late engine answer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Interrupt request |
| eng_go | output | 1 | One-cycle request to the bit timing engine |
| eng_op | output | 2 | Requested operation: 0 START, 1 STOP, 2 transmit, 3 receive |
| eng_wbyte | output | 8 | Byte to transmit |
| eng_nack | output | 1 | Answer a received byte with NACK |
| eng_rst | output | 1 | Engine reset, high during soft reset |
| eng_done | input | 1 | One-cycle pulse: requested operation finished |
| eng_ack | input | 1 | Target acknowledged the transmitted byte (valid with `eng_done`) |
| eng_rbyte | input | 8 | Received byte (valid with `eng_done`) |

## Verification
Software clearing the done flag can land in the same cycle as the sequencer raising it, when the list runs out. The bench provokes this with a one-command list and an engine that answers in a fixed cycle, so the write-1-to-clear is placed on exactly the edge where done is set. Done must still read 1 afterwards. The same clear issued one cycle later must leave it at 0. Error setting against clearing is covered by the assertion on the NACK halt.

// File: rtl/i2c_cmdseq.sv
module i2c_cmdseq #(
  parameter int CMD_DEPTH  = 16,
  parameter int DATA_BYTES = 16,
  parameter int RST_CYCLES = 4,
  parameter int AW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          eng_go,
  output logic [1:0]    eng_op,
  output logic [7:0]    eng_wbyte,
  output logic          eng_nack,
  output logic          eng_rst,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [7:0]    eng_rbyte
);

  localparam int CIW    = $clog2(CMD_DEPTH);
  localparam int IDXW   = CIW + 1;
  localparam int DIW    = $clog2(DATA_BYTES);
  localparam int DWORDS = DATA_BYTES / 4;
  localparam int RCW    = $clog2(RST_CYCLES + 1);

  localparam logic [AW-1:0] A_CTRL     = AW'(0);
  localparam logic [AW-1:0] A_STAT     = AW'(1);
  localparam logic [AW-1:0] A_TRIG     = AW'(2);
  localparam logic [AW-1:0] CMD_BASE_A = AW'(CMD_DEPTH);
  localparam logic [AW-1:0] DAT_BASE_A = AW'(2 * CMD_DEPTH);
  localparam logic [AW-1:0] CMD_N      = AW'(CMD_DEPTH);
  localparam logic [AW-1:0] DW_N       = AW'(DWORDS);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_WR    = 2'd2;
  localparam logic [1:0] OP_RD    = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} state_t;

  state_t          state;
  logic [7:0]      cbuf [CMD_DEPTH];
  logic [7:0]      dbuf [DATA_BYTES];
  logic            ctl_en, ctl_master, ie_done, ie_err;
  logic [RCW-1:0]  rst_cnt;
  logic            nack_f, tint_f, stop_f, done_f, err_f;
  logic [IDXW-1:0] idx, run_len, fill_len;
  logic            c_start, c_stop, c_rd, c_wr, c_nack;
  logic [3:0]      rep_left;
  logic [DIW-1:0]  rd_n;
  logic            go_q, nack_q;
  logic [1:0]      op_q;
  logic [7:0]      wbyte_q;

  logic [AW-1:0]   cmd_off, dat_off;
  logic [CIW-1:0]  cidx;
  logic [IDXW-1:0] cmd_end;
  logic [7:0]      cur_cmd, nxt_byte;
  logic            rst_act, wr_ok, wr_ctrl, wr_stat, wr_cmd, trig_go, trig_stop, data_pend;
  logic            unused_bits;

  assign rst_act   = rst_cnt != '0;
  assign wr_ok     = reg_we && !rst_act;
  assign cmd_off   = reg_addr - CMD_BASE_A;
  assign dat_off   = reg_addr - DAT_BASE_A;
  assign cidx      = cmd_off[CIW-1:0];
  assign cmd_end   = IDXW'(cidx) + IDXW'(1);
  assign wr_ctrl   = wr_ok && reg_addr == A_CTRL;
  assign wr_stat   = wr_ok && reg_addr == A_STAT;
  assign wr_cmd    = wr_ok && cmd_off < CMD_N;
  assign trig_go   = wr_ok && reg_addr == A_TRIG && reg_wdata[0] && state == S_IDLE
                     && ctl_en && ctl_master;
  assign trig_stop = wr_ok && reg_addr == A_TRIG && !reg_wdata[0];
  assign cur_cmd   = cbuf[idx[CIW-1:0]];
  assign nxt_byte  = cbuf[idx[CIW-1:0] + CIW'(1)];
  assign data_pend = (c_wr || c_rd) && rep_left != 4'd0;
  assign unused_bits = ^{reg_wdata[31:13], reg_wdata[10]};

  assign eng_go    = go_q;
  assign eng_op    = op_q;
  assign eng_wbyte = wbyte_q;
  assign eng_nack  = nack_q;
  assign eng_rst   = rst_act;
  assign irq       = (done_f && ie_done) || (err_f && ie_err);

  always_ff @(posedge clk) begin
    if (wr_cmd) cbuf[cidx] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      for (int i = 0; i < DATA_BYTES; i++) dbuf[i] <= '0;
      {ctl_en, ctl_master, ie_done, ie_err} <= '0;
      rst_cnt <= '0;
      {nack_f, tint_f, stop_f, done_f, err_f} <= '0;
      idx <= '0; run_len <= '0; fill_len <= '0;
      {c_start, c_stop, c_rd, c_wr, c_nack} <= '0;
      rep_left <= '0; rd_n <= '0;
      go_q <= 1'b0; nack_q <= 1'b0; op_q <= OP_START; wbyte_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (rst_act) begin
        rst_cnt <= rst_cnt - RCW'(1);
        state <= S_IDLE;
        for (int i = 0; i < DATA_BYTES; i++) dbuf[i] <= '0;
        {nack_f, tint_f, stop_f, done_f, err_f} <= '0;
        idx <= '0; run_len <= '0; fill_len <= '0; rd_n <= '0;
        {c_start, c_stop, c_rd, c_wr, c_nack} <= '0;
        rep_left <= '0;
      end else begin
        if (wr_stat) begin
          if (reg_wdata[2]) nack_f <= 1'b0;
          if (reg_wdata[4]) tint_f <= 1'b0;
          if (reg_wdata[8]) done_f <= 1'b0;
          if (reg_wdata[9]) err_f  <= 1'b0;
        end

        case (state)
          S_FETCH: begin
            if (idx >= run_len) begin
              done_f <= 1'b1;
              state  <= S_IDLE;
            end else begin
              {c_start, c_stop, c_rd, c_wr, c_nack} <= cur_cmd[7:3];
              rep_left <= {1'b0, cur_cmd[2:0]} + 4'd1;
              state    <= S_ISSUE;
            end
          end
          S_ISSUE: begin
            if (c_start) begin
              go_q <= 1'b1; op_q <= OP_START; nack_q <= 1'b0; state <= S_WAIT;
            end else if (data_pend) begin
              go_q    <= 1'b1;
              op_q    <= c_wr ? OP_WR : OP_RD;
              wbyte_q <= nxt_byte;
              nack_q  <= !c_wr && c_nack && rep_left == 4'd1;
              state   <= S_WAIT;
            end else if (c_stop) begin
              go_q <= 1'b1; op_q <= OP_STOP; nack_q <= 1'b0; state <= S_WAIT;
            end else begin
              idx   <= idx + (c_wr ? IDXW'(2) : IDXW'(1));
              state <= S_FETCH;
            end
          end
          S_WAIT: begin
            if (eng_done) begin
              state <= S_ISSUE;
              case (op_q)
                OP_START: c_start <= 1'b0;
                OP_STOP: begin
                  c_stop <= 1'b0;
                  stop_f <= 1'b1;
                end
                OP_WR: begin
                  if (!eng_ack) begin
                    err_f  <= 1'b1;
                    nack_f <= 1'b1;
                    state  <= S_IDLE;
                  end else begin
                    rep_left <= rep_left - 4'd1;
                    tint_f   <= 1'b1;
                  end
                end
                default: begin
                  dbuf[rd_n] <= eng_rbyte;
                  rd_n       <= rd_n + DIW'(1);
                  rep_left   <= rep_left - 4'd1;
                  tint_f     <= 1'b1;
                end
              endcase
            end
          end
          default: ;
        endcase

        if (wr_ctrl) begin
          ctl_en     <= reg_wdata[1];
          ctl_master <= reg_wdata[2];
          ie_done    <= reg_wdata[11];
          ie_err     <= reg_wdata[12];
          if (reg_wdata[0]) rst_cnt <= RCW'(RST_CYCLES);
        end
        if (wr_cmd && cmd_end > fill_len) fill_len <= cmd_end;
        if (trig_go) begin
          state    <= S_FETCH;
          idx      <= '0;
          run_len  <= fill_len;
          fill_len <= '0;
          rd_n     <= '0;
          stop_f   <= 1'b0;
        end
        if (trig_stop) state <= S_IDLE;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[0]  = rst_act;
      reg_rdata[1]  = ctl_en;
      reg_rdata[2]  = ctl_master;
      reg_rdata[11] = ie_done;
      reg_rdata[12] = ie_err;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[0]  = state != S_IDLE;
      reg_rdata[1]  = state == S_WAIT;
      reg_rdata[2]  = nack_f;
      reg_rdata[4]  = tint_f;
      reg_rdata[6]  = stop_f;
      reg_rdata[8]  = done_f;
      reg_rdata[9]  = err_f;
      reg_rdata[16 +: IDXW] = idx;
    end else if (cmd_off < CMD_N) begin
      reg_rdata[7:0] = cbuf[cidx];
    end else if (dat_off < DW_N) begin
      for (int b = 0; b < 4; b++)
        reg_rdata[8*b +: 8] = dbuf[{dat_off[DIW-3:0], 2'(b)}];
    end
  end

  p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);

  p_go_from_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> $past(state) == S_ISSUE);

  p_nack_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && op_q == OP_WR && eng_done && !eng_ack && !rst_act && !trig_stop)
    |=> (state == S_IDLE && err_f && nack_f && $stable(idx)));

  p_rst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (state == S_IDLE && !done_f && !err_f && !eng_go));

  p_done_at_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> (idx >= run_len && state == S_IDLE));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_f || err_f));

endmodule

// File: tb/i2c_cmdseq_bench.sv
module i2c_cmdseq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, eng_go, eng_nack, eng_rst;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wbyte;
  logic        eng_done, eng_ack;
  logic [7:0]  eng_rbyte;

  always #4 clk = ~clk;

  i2c_cmdseq u_i2c_cmdseq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_go(eng_go), .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_nack(eng_nack),
    .eng_rst(eng_rst), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rbyte(eng_rbyte)
  );

  // {cmd, data entry, op count, ops (2 bits each, first op lowest), nack mask, pad}
  localparam logic [47:0] VEC [10] = '{
    {8'h90, 8'hA0, 4'd2, 16'h0008, 8'h00, 4'h0},
    {8'h50, 8'h5A, 4'd2, 16'h0006, 8'h00, 4'h0},
    {8'hD0, 8'h3C, 4'd3, 16'h0018, 8'h00, 4'h0},
    {8'h20, 8'h00, 4'd1, 16'h0003, 8'h00, 4'h0},
    {8'h28, 8'h00, 4'd1, 16'h0003, 8'h01, 4'h0},
    {8'h6A, 8'h00, 4'd4, 16'h007F, 8'h04, 4'h0},
    {8'hC0, 8'h00, 4'd2, 16'h0004, 8'h00, 4'h0},
    {8'h13, 8'hE7, 4'd4, 16'h00AA, 8'h00, 4'h0},
    {8'h00, 8'h00, 4'd0, 16'h0000, 8'h00, 4'h0},
    {8'hB8, 8'h81, 4'd2, 16'h0008, 8'h00, 4'h0}
  };

  int checks = 0;
  int fails  = 0;
  int lat    = 1;
  int nak_wr = -1;
  int wr_seen, nlog, rcount;
  logic [1:0]  lop   [64];
  logic [7:0]  lbyte [64];
  logic        lnack [64];
  logic        ack_tmp;
  logic [31:0] s;

  initial begin
    eng_done = 1'b0; eng_ack = 1'b1; eng_rbyte = 8'h00;
    nlog = 0; wr_seen = 0; rcount = 0;
    forever begin
      @(negedge clk);
      if (eng_go === 1'b1) begin
        if (nlog < 64) begin
          lop[nlog] = eng_op; lbyte[nlog] = eng_wbyte; lnack[nlog] = eng_nack;
        end
        nlog++;
        ack_tmp = 1'b1;
        if (eng_op == 2'd2) begin
          if (wr_seen == nak_wr) ack_tmp = 1'b0;
          wr_seen++;
        end
        eng_rbyte = 8'h40 + rcount[7:0];
        if (eng_op == 2'd3) rcount++;
        repeat (lat - 1) @(negedge clk);
        eng_done = 1'b1;
        eng_ack  = ack_tmp;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_log();
    nlog = 0; wr_seen = 0; rcount = 0;
  endtask

  task automatic run_wait();
    logic [31:0] st;
    wr(6'd2, 32'h1);
    for (int k = 0; k < 3000; k++) begin
      rd(6'd1, st);
      if (!st[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(6'd1, s); chk("R1 status", s, 32'h0);
    rd(6'd0, s); chk("R1 control", s, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 eng_go", {31'b0, eng_go}, 32'h0);
    chk("R1 eng_rst", {31'b0, eng_rst}, 32'h0);

    wr(6'd16, 32'h80);
    wr(6'd2, 32'h1);
    repeat (6) @(negedge clk);
    rd(6'd1, s); chk("R2 launch ignored while disabled", {31'b0, s[0]}, 32'h0);
    chk("R2 no engine request", nlog, 0);
    wr(6'd0, 32'h1806);
    rd(6'd0, s); chk("R2 control enables", s, 32'h1806);

    for (int r = 0; r < 10; r++) begin
      logic [7:0]  cmd, dat;
      logic [3:0]  nops;
      logic [15:0] ops;
      logic [7:0]  nm;
      logic [31:0] exp_st;
      {cmd, dat, nops, ops, nm} = VEC[r][47:4];
      wr(6'd1, 32'h314);
      clear_log();
      wr(6'd16, {24'b0, cmd});
      if (cmd[4]) wr(6'd17, {24'b0, dat});
      run_wait();
      chk($sformatf("R3 row %0d op count", r), nlog, {28'b0, nops});
      for (int i = 0; i < int'(nops); i++) begin
        chk($sformatf("R3 row %0d op %0d", r, i), {30'b0, lop[i]}, {30'b0, ops[2*i +: 2]});
        chk($sformatf("R6 row %0d nack %0d", r, i), {31'b0, lnack[i]}, {31'b0, nm[i]});
        if (ops[2*i +: 2] == 2'd2)
          chk($sformatf("R4 row %0d byte %0d", r, i), {24'b0, lbyte[i]}, {24'b0, dat});
      end
      exp_st = 32'h100 | ((cmd[4] ? 32'd2 : 32'd1) << 16)
             | (cmd[6] ? 32'h40 : 32'h0) | ((cmd[5] | cmd[4]) ? 32'h10 : 32'h0);
      rd(6'd1, s); chk($sformatf("R7 row %0d status", r), s, exp_st);
      chk($sformatf("R11 row %0d irq", r), {31'b0, irq}, 32'h1);
    end

    wr(6'd1, 32'h314);
    clear_log();
    wr(6'd16, 32'h90); wr(6'd17, 32'hA1);
    for (int e = 18; e < 23; e++) wr(6'(e), 32'h20);
    wr(6'd23, 32'h68);
    run_wait();
    chk("R4 address then reads op count", nlog, 9);
    chk("R4 address byte", {24'b0, lbyte[1]}, 32'hA1);
    chk("R3 final stop", {30'b0, lop[8]}, 32'h1);
    chk("R6 nack on last read", {31'b0, lnack[7]}, 32'h1);
    chk("R6 ack on earlier read", {31'b0, lnack[6]}, 32'h0);
    rd(6'd32, s); chk("R5 data word 0", s, 32'h43424140);
    rd(6'd33, s); chk("R5 data word 1", s, 32'h00004544);
    rd(6'd1, s);  chk("R7 status after long list", s, 32'h00080150);

    wr(6'd1, 32'h314);
    clear_log();
    nak_wr = 0;
    wr(6'd16, 32'h90); wr(6'd17, 32'h42); wr(6'd18, 32'h50); wr(6'd19, 32'h11);
    run_wait();
    repeat (10) @(negedge clk);
    nak_wr = -1;
    chk("R8 no request after nack", nlog, 2);
    rd(6'd1, s); chk("R8 error status", s, 32'h00000204);
    chk("R11 irq on error", {31'b0, irq}, 32'h1);
    wr(6'd1, 32'h200);
    rd(6'd1, s); chk("R9 error cleared nack kept", s, 32'h4);
    chk("R11 irq after clear", {31'b0, irq}, 32'h0);

    wr(6'd0, 32'h1807);
    rd(6'd0, s); chk("R10 reset bit reads 1", s, 32'h1807);
    chk("R10 eng_rst high", {31'b0, eng_rst}, 32'h1);
    repeat (6) @(negedge clk);
    rd(6'd0, s); chk("R10 reset self-clears", s, 32'h1806);
    chk("R10 eng_rst low", {31'b0, eng_rst}, 32'h0);
    rd(6'd1, s); chk("R10 status cleared", s, 32'h0);
    rd(6'd32, s); chk("R10 data cleared", s, 32'h0);
    clear_log();
    wr(6'd16, 32'h90); wr(6'd17, 32'h42);
    run_wait();
    rd(6'd1, s); chk("R10 run after reset", s, 32'h00020110);
    chk("R10 requests after reset", nlog, 2);

    wr(6'd1, 32'h314);
    clear_log();
    lat = 20;
    wr(6'd16, 32'h20); wr(6'd17, 32'h20);
    wr(6'd2, 32'h1);
    repeat (5) @(negedge clk);
    wr(6'd2, 32'h0);
    rd(6'd1, s); chk("R12 busy dropped", {31'b0, s[0]}, 32'h0);
    repeat (60) @(negedge clk);
    rd(6'd1, s); chk("R12 done not set", {31'b0, s[8]}, 32'h0);
    chk("R12 late answer ignored", nlog, 1);
    lat = 1;

    // done set and done clear on the same edge: set wins
    wr(6'd1, 32'h314);
    clear_log();
    wr(6'd16, 32'h80);
    wr(6'd2, 32'h1);
    repeat (3) @(negedge clk);
    wr(6'd1, 32'h100);
    rd(6'd1, s); chk("R9 set wins over same-cycle clear", {31'b0, s[8]}, 32'h1);
    wr(6'd1, 32'h314);
    wr(6'd16, 32'h80);
    wr(6'd2, 32'h1);
    repeat (4) @(negedge clk);
    wr(6'd1, 32'h100);
    rd(6'd1, s); chk("R9 clear one cycle later", s[8:0], 32'h0);

    finish_run();
  end
endmodule